// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Split Dot-Product Mode

This block is a two-stage arithmetic pipeline for filter and transform kernels. Each cycle it can accept a pair of 18-bit operands together with a product mode and an accumulator command. The first stage forms a product. That product is a full signed product, an unsigned product of the low 17 bits, or a dot product of the 9-bit operand halves. The dot product takes the two cross terms, adds them and scales the sum up by nine bit positions. The product is then sign- or zero-extended to 44 bits.

The second stage combines the product with a 44-bit running sum. It can add the product, subtract it, or start a new sum from zero. A typical FIR tap loop issues the first tap with the accumulate control low and the remaining taps with it high, and reads the sum once the last tap's valid output appears. Arithmetic wraps modulo 2^44. There is no saturation, cascade path or coefficient storage.

Top module: `mac_dot_unit`

## Requirements
- R1: While and after a synchronous reset, `out_valid` is 0 and `result` is 0 until a valid operation completes.
- R2: With `mode` = 2'b00, the product is the signed 18x18 product of `op_a` and `op_b`, sign-extended to 44 bits.
- R3: With `mode` = 2'b01, the product is the unsigned product of `op_a[16:0]` and `op_b[16:0]`, zero-extended. Bit 17 of each operand has no effect.
- R4: With `mode` = 2'b10, the product is (`op_a[8:0]`*`op_b[17:9]` + `op_a[17:9]`*`op_b[8:0]`) * 512. Each 9-bit half is read as two's complement, and the result is sign-extended.
- R5: With `mode` = 2'b11, the product is the same dot-product expression as in R4, but with each 9-bit half read as unsigned.
- R6: With `acc_en` = 1 and `sub_en` = 0, the new result is the previous result plus the product.
- R7: With `sub_en` = 1, the product is subtracted instead of added. The base is the previous result when `acc_en` = 1, and zero when `acc_en` = 0.
- R8: With `acc_en` = 0, the previous sum is discarded, so the result becomes the product (or its negation, per R7).
- R9: `out_valid` rises exactly two clock edges after an accepted `in_valid`. The unit accepts a new operation on every cycle, and back-to-back operations chain into the sum.
- R10: A cycle with `in_valid` = 0 leaves `result` unchanged, whatever the values of the operand and control inputs.
- R11: Sums that overflow or underflow 44 bits wrap modulo 2^44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 18 | Operand A |
| op_b | input | 18 | Operand B |
| mode | input | 2 | Product mode: 00 signed, 01 unsigned 17-bit, 10 signed-half dot, 11 unsigned-half dot |
| acc_en | input | 1 | 1 = combine with running sum, 0 = start a new sum |
| sub_en | input | 1 | 1 = subtract the product, 0 = add it |
| out_valid | output | 1 | Result reflects a newly completed operation |
| result | output | 44 | Registered accumulator value |

## Verification
The first part is a sweep of every product mode over a grid of corner operand values: zero, ±1, the extreme positives and negatives, alternating bit patterns, and values that differ only in bit 17 or bit 8. Each operation is issued as a fresh load, so sign extension, the ignored top bit of the unsigned mode, and the signed versus unsigned reading of the halves each show up as separate mismatches. A long back-to-back stream then mixes add, subtract and load commands on pseudo-random operands, which exposes wrong latency and wrong command priority. Idle cycles with scrambled controls confirm that the sum holds. Long chains of maximum products, plus a subtraction from zero, push the sum across the 44-bit boundary in both directions.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int MAC_OP_W  = 18;
    localparam int MAC_ACC_W = 44;

    typedef enum logic [1:0] {
        MD_SFULL = 2'b00,
        MD_UFULL = 2'b01,
        MD_SDOT  = 2'b10,
        MD_UDOT  = 2'b11
    } mac_mode_e;

    typedef struct packed {
        logic vld;
        logic acc_en;
        logic sub;
    } mac_ctl_t;

    function automatic logic mode_is_dot(input mac_mode_e m);
        return (m == MD_SDOT) || (m == MD_UDOT);
    endfunction

    function automatic logic mode_halves_signed(input mac_mode_e m);
        return m == MD_SDOT;
    endfunction

endpackage

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
    import mac_pkg::*;
#(
    parameter int OP_W  = MAC_OP_W,
    parameter int ACC_W = MAC_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  mac_ctl_t          ctl_in,
    input  mac_mode_e         mode_in,
    input  logic [OP_W-1:0]   a_in,
    input  logic [OP_W-1:0]   b_in,
    output mac_ctl_t          ctl_q,
    output logic [ACC_W-1:0]  prod_q
);
    localparam int HALF  = OP_W / 2;
    localparam int UW    = OP_W - 1;
    localparam int HX    = HALF + 1;
    localparam int XPW   = 2 * HX;
    localparam int DSUMW = XPW + 1;

    logic signed [2*OP_W-1:0] p_sfull;
    logic        [2*UW-1:0]   p_ufull;
    logic                     hsgn;
    logic signed [HX-1:0]     a_lo, a_hi, b_lo, b_hi;
    logic signed [XPW-1:0]    x_lohi, x_hilo;
    logic signed [DSUMW-1:0]  dot_sum;
    logic signed [ACC_W-1:0]  sfull_ext, dot_ext;
    logic        [ACC_W-1:0]  prod_d;

    assign p_sfull = $signed(a_in) * $signed(b_in);
    assign p_ufull = a_in[UW-1:0] * b_in[UW-1:0];

    // halves get one extra top bit: a copy of the sign bit or zero
    assign hsgn = mode_halves_signed(mode_in);
    assign a_lo = $signed({hsgn & a_in[HALF-1], a_in[HALF-1:0]});
    assign a_hi = $signed({hsgn & a_in[OP_W-1], a_in[OP_W-1:HALF]});
    assign b_lo = $signed({hsgn & b_in[HALF-1], b_in[HALF-1:0]});
    assign b_hi = $signed({hsgn & b_in[OP_W-1], b_in[OP_W-1:HALF]});

    assign x_lohi  = a_lo * b_hi;
    assign x_hilo  = a_hi * b_lo;
    assign dot_sum = DSUMW'(x_lohi) + DSUMW'(x_hilo);

    assign sfull_ext = ACC_W'(p_sfull);
    assign dot_ext   = ACC_W'(dot_sum);

    always_comb begin
        unique case (mode_in)
            MD_SFULL: prod_d = sfull_ext;
            MD_UFULL: prod_d = {{(ACC_W-2*UW){1'b0}}, p_ufull};
            default:  prod_d = dot_ext <<< HALF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (ctl_in.vld) begin
            prod_q <= prod_d;
        end
    end

    a_r3_unsigned_top_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl_in.vld && mode_in == MD_UFULL) |=> (prod_q[ACC_W-1:2*UW] == '0));

    a_r4_dot_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (ctl_in.vld && mode_is_dot(mode_in)) |=> (prod_q[HALF-1:0] == '0));

    a_r5_udot_nonneg: assert property (@(posedge clk) disable iff (rst)
        (ctl_in.vld && mode_in == MD_UDOT) |=> !prod_q[ACC_W-1]);

endmodule

// File: rtl/mac_accum_stage.sv
module mac_accum_stage
    import mac_pkg::*;
#(
    parameter int ACC_W = MAC_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  mac_ctl_t          ctl_in,
    input  logic [ACC_W-1:0]  prod_in,
    output logic              out_v,
    output logic [ACC_W-1:0]  acc_q
);
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] next_sum;

    assign base     = ctl_in.acc_en ? acc_q : '0;
    assign next_sum = ctl_in.sub ? (base - prod_in) : (base + prod_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            out_v <= 1'b0;
        end else begin
            out_v <= ctl_in.vld;
            if (ctl_in.vld) begin
                acc_q <= next_sum;
            end
        end
    end

    a_r9_valid_one_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_v == $past(ctl_in.vld)));

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl_in.vld)) |-> $stable(acc_q));

    a_r8_load_takes_product: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl_in.vld) && !$past(ctl_in.acc_en) && !$past(ctl_in.sub))
        |-> (acc_q == $past(prod_in)));

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (acc_q == '0 && !out_v));

endmodule

// File: rtl/mac_dot_unit.sv
module mac_dot_unit
    import mac_pkg::*;
#(
    parameter int OP_W  = MAC_OP_W,
    parameter int ACC_W = MAC_ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic [1:0]        mode,
    input  logic              acc_en,
    input  logic              sub_en,
    output logic              out_valid,
    output logic [ACC_W-1:0]  result
);
    mac_ctl_t         ctl_s0, ctl_s1;
    logic [ACC_W-1:0] prod_s1;

    assign ctl_s0 = '{vld: in_valid, acc_en: acc_en, sub: sub_en};

    mac_mult_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .clk     (clk),
        .rst     (rst),
        .ctl_in  (ctl_s0),
        .mode_in (mac_mode_e'(mode)),
        .a_in    (op_a),
        .b_in    (op_b),
        .ctl_q   (ctl_s1),
        .prod_q  (prod_s1)
    );

    mac_accum_stage #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .ctl_in  (ctl_s1),
        .prod_in (prod_s1),
        .out_v   (out_valid),
        .acc_q   (result)
    );

    a_r9_two_cycle_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

endmodule

// File: tb/sim_mac_dot_unit.sv
module sim_mac_dot_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [17:0] op_a, op_b;
    logic [1:0]  mode;
    logic        acc_en, sub_en;
    logic        out_valid;
    logic [43:0] result;

    int total = 0;
    int bad   = 0;
    longint model_acc = 0;
    localparam longint MASK44 = (64'd1 << 44) - 1;

    always #2 clk = ~clk;

    mac_dot_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .acc_en(acc_en), .sub_en(sub_en),
        .out_valid(out_valid), .result(result)
    );

    function automatic longint mdl_prod(input logic [17:0] a, input logic [17:0] b,
                                        input logic [1:0] m);
        longint al, ah, bl, bh;
        case (m)
            2'b00: return longint'($signed(a)) * longint'($signed(b));
            2'b01: return longint'(a[16:0]) * longint'(b[16:0]);
            2'b10: begin
                al = longint'($signed(a[8:0]));  ah = longint'($signed(a[17:9]));
                bl = longint'($signed(b[8:0]));  bh = longint'($signed(b[17:9]));
                return (al * bh + ah * bl) * 512;
            end
            default: begin
                al = longint'(a[8:0]);  ah = longint'(a[17:9]);
                bl = longint'(b[8:0]);  bh = longint'(b[17:9]);
                return (al * bh + ah * bl) * 512;
            end
        endcase
    endfunction

    function automatic longint mdl_step(input longint acc, input longint p,
                                        input logic ae, input logic se);
        longint base;
        base = ae ? acc : 0;
        return (se ? base - p : base + p) & MASK44;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [17:0] a, input logic [17:0] b,
                         input logic [1:0] m, input logic ae, input logic se);
        in_valid = v; op_a = a; op_b = b; mode = m; acc_en = ae; sub_en = se;
        if (v) model_acc = mdl_step(model_acc, mdl_prod(a, b, m), ae, se);
    endtask

    // single op: drive, idle one cycle, sample two edges after issue
    task automatic one_op(input string tag, input logic [17:0] a, input logic [17:0] b,
                          input logic [1:0] m, input logic ae, input logic se);
        @(negedge clk); drive(1'b1, a, b, m, ae, se);
        @(negedge clk); drive(1'b0, 18'h0, 18'h0, 2'b00, 1'b0, 1'b0);
        @(negedge clk);
        check({tag, " result"}, longint'(result), model_acc);
        check({tag, " out_valid"}, longint'(out_valid), 1);
    endtask

    logic [17:0] pats [10];
    string rtag [4];

    initial begin
        pats[0] = 18'h00000; pats[1] = 18'h00001; pats[2] = 18'h3FFFF; pats[3] = 18'h1FFFF;
        pats[4] = 18'h20000; pats[5] = 18'h15555; pats[6] = 18'h2AAAA; pats[7] = 18'h000FF;
        pats[8] = 18'h20100; pats[9] = 18'h3FE01;
        rtag[0] = "R2"; rtag[1] = "R3"; rtag[2] = "R4"; rtag[3] = "R5";

        rst = 1'b1;
        drive(1'b0, 18'h0, 18'h0, 2'b00, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 reset result", longint'(result), 0);
        check("R1 reset out_valid", longint'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset out_valid", longint'(out_valid), 0);
        check("R1 post-reset result", longint'(result), 0);

        // R2 R3 R4 R5 R8: every mode over the operand grid, each as a fresh load
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    one_op({rtag[m], " R8 load"}, pats[i], pats[j], 2'(m), 1'b0, 1'b0);

        // R3: bit 17 ignored in unsigned mode
        one_op("R3 bit17 set", 18'h3FFFF, 18'h20003, 2'b01, 1'b0, 1'b0);
        check("R3 bit17 value", longint'(result), longint'(17'h1FFFF) * 3);

        // R6 R7: chained add and subtract
        one_op("R8 load base", 18'h00100, 18'h00010, 2'b00, 1'b0, 1'b0);
        one_op("R6 add", 18'h3FFFE, 18'h00005, 2'b00, 1'b1, 1'b0);
        one_op("R7 sub accumulate", 18'h00007, 18'h00003, 2'b01, 1'b1, 1'b1);
        one_op("R7 sub from zero on load", 18'h00009, 18'h00004, 2'b00, 1'b0, 1'b1);
        check("R7 negated load value", longint'(result), (-36) & MASK44);

        // R10: idle cycles with scrambled controls keep the sum
        begin
            longint held;
            held = longint'(result);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                drive(1'b0, 18'h2AAAA ^ 18'(k), 18'h15555, 2'(k), 1'b0, k[0]);
                check("R10 idle hold", longint'(result), held);
            end
            @(negedge clk);
            check("R10 idle no valid", longint'(out_valid), 0);
        end

        // R9 R6 R7 R8: back-to-back stream, checked every cycle
        begin
            longint exp_q [4];
            logic [31:0] lf;
            lf = 32'hACE1_2468;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (k >= 2) begin
                    check("R9 stream result", longint'(result), exp_q[(k-2)%4]);
                    check("R9 stream out_valid", longint'(out_valid), 1);
                end
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                drive(1'b1, lf[17:0], lf[31:14], lf[5:4], (lf[9:7] != 3'b000), lf[12]);
                exp_q[k%4] = model_acc;
            end
            @(negedge clk); drive(1'b0, 18'h0, 18'h0, 2'b00, 1'b0, 1'b0);
            check("R9 stream tail-1", longint'(result), exp_q[398%4]);
            @(negedge clk);
            check("R9 stream tail", longint'(result), exp_q[399%4]);
            @(negedge clk);
            check("R9 stream drains", longint'(out_valid), 0);
        end

        // R11: wrap below zero and past 2^44
        one_op("R11 load zero", 18'h0, 18'h0, 2'b00, 1'b0, 1'b0);
        one_op("R11 underflow", 18'h20000, 18'h20000, 2'b00, 1'b1, 1'b1);
        check("R11 underflow value", longint'(result), (64'd1 << 44) - (64'd1 << 34));
        begin
            longint exp_q [4];
            for (int k = 0; k < 1100; k++) begin
                @(negedge clk);
                if (k >= 2) check("R11 overflow chain", longint'(result), exp_q[(k-2)%4]);
                drive(1'b1, 18'h20000, 18'h20000, 2'b00, 1'b1, 1'b0);
                exp_q[k%4] = model_acc;
            end
            @(negedge clk); drive(1'b0, 18'h0, 18'h0, 2'b00, 1'b0, 1'b0);
            @(negedge clk);
            check("R11 overflow final", longint'(result), exp_q[1099%4]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule